// File: doc/BRIEF.md
# ECC Error Logging Register Unit

This unit is the software-visible status and control point beside a DRAM controller's single-error-correct, double-error-detect decoder. Each cycle the decoder may pulse a correctable or an uncorrectable error indication together with the failing address. The unit counts both kinds of event in separate saturating counters. It keeps the address of the first uncorrectable event and the address of the latest correctable event. It raises a level-high interrupt while an enabled event class has a nonzero count.

Software reaches the unit over a simple 32-bit register bus. A write takes effect on the clock edge where the write enable is high. Read data is combinational from the address. Every write except one to the key register is refused unless the unit has been unlocked with a fixed key value. Software acknowledges events by setting a clear bit, which empties the counters and the address holders. It then writes that bit back to zero. Two configuration bits, the ECC-on flag and the DRAM type, are driven out as ports for the controller.

Top module: `ecc_errlog_regs`

## Requirements
- R1: After reset the unit is locked, and the configuration, enable and clear bits, both counters and both address registers are zero. `irq` is low and both configuration outputs are low.
- R2: A write to offset 0x00 is always accepted. If the data equals 0xFC600309 the unit becomes unlocked, and any other value (for example 0x039FFCF6) locks it. Offset 0x00 reads 1 when unlocked and 0 when locked.
- R3: While the unit is locked, writes to the configuration register (0x04) and the interrupt control register (0x50) leave them unchanged.
- R4: The configuration register at 0x04 reads back the full 32-bit value last written. Bit 7 drives `cfg_ecc_on` and bit 4 drives `cfg_ddr4`, where 1 means DDR4 and 0 means DDR3.
- R5: Bit 31 of 0x50 is the clear bit and reads back as written. During the cycle of a write that sets it, and in every cycle while it stays set, both counters and both address registers are forced to zero and error pulses are discarded. A clear in the same cycle as an error pulse wins. `irq` is low in the cycle after a clear.
- R6: The correctable count reads at 0x50 bits 23:16 and saturates at 255. The uncorrectable count reads at bits 15:12 and saturates at 15. Each counter adds one per pulse that is not discarded.
- R7: Offset 0x58 holds the address of the first uncorrectable error since reset or the last clear. Later uncorrectable errors do not change it, and after a clear the next one is captured again.
- R8: Offset 0x5C holds the address of the most recent correctable error.
- R9: Bits 1:0 of 0x50 are enables: bit 0 for correctable and bit 1 for uncorrectable. `irq` is high exactly when (bit 0 and the correctable count is nonzero) or (bit 1 and the uncorrectable count is nonzero).
- R10: Offsets 0x58 and 0x5C ignore writes. Unmapped offsets read zero, and bits 30:24, 11:2 of 0x50 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ce_pulse | input | 1 | One-cycle correctable error event |
| ue_pulse | input | 1 | One-cycle uncorrectable error event |
| err_addr | input | ERR_ADDR_W | Failing address that goes with either pulse |
| irq | output | 1 | Active-high interrupt |
| cfg_ecc_on | output | 1 | Configuration bit 7, ECC enabled |
| cfg_ddr4 | output | 1 | Configuration bit 4, DRAM type |

## Verification
The hardest state to reach from the ports is an error pulse that arrives in the exact cycle a clear-setting write lands. In that cycle the clear bit is not yet registered, so only the write path can suppress the pulse. The bench drives the pulse and the write in the same cycle, then releases the clear and fires one more uncorrectable event to show that the first-address holder has re-armed. The saturation corners are reached by running the correctable counter 260 pulses deep and the uncorrectable counter 20 deep, with the expected field computed each step.

// File: rtl/ecc_errlog_pkg.sv
package ecc_errlog_pkg;
    localparam logic [31:0] DEFAULT_KEY = 32'hFC60_0309;

    localparam int OFS_KEY   = 'h00;
    localparam int OFS_CFG   = 'h04;
    localparam int OFS_ICTL  = 'h50;
    localparam int OFS_UEADR = 'h58;
    localparam int OFS_CEADR = 'h5C;

    localparam int CE_CNT_W   = 8;
    localparam int UE_CNT_W   = 4;
    localparam int CE_CNT_LSB = 16;
    localparam int UE_CNT_LSB = 12;
    localparam int CLR_BIT    = 31;
    localparam int CFG_ECC_BIT  = 7;
    localparam int CFG_TYPE_BIT = 4;

    typedef struct packed {
        logic        unlocked;
        logic [31:0] cfg;
        logic [1:0]  en;
        logic        clr;
    } ctl_state_t;
endpackage

// File: rtl/errlog_satcnt.sv
module errlog_satcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc && cnt_q != MAXV)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == MAXV && inc && !clr) |=> (cnt_q == MAXV)); // R6
    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/errlog_addr_hold.sv
module errlog_addr_hold #(
    parameter int W          = 32,
    parameter bit KEEP_FIRST = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         hit,
    input  logic [W-1:0] addr,
    output logic [W-1:0] val
);
    typedef struct packed {
        logic         valid;
        logic [W-1:0] val;
    } hold_t;

    hold_t st_d, st_q;

    generate
        if (KEEP_FIRST) begin : g_first
            always_comb begin
                st_d = st_q;
                if (clr)
                    st_d = '0;
                else if (hit && !st_q.valid) begin
                    st_d.valid = 1'b1;
                    st_d.val   = addr;
                end
            end

            AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.valid && !clr) |=> $stable(st_q.val)); // R7
        end else begin : g_last
            always_comb begin
                st_d = st_q;
                if (clr)
                    st_d = '0;
                else if (hit) begin
                    st_d.valid = 1'b1;
                    st_d.val   = addr;
                end
            end

            AST_LAST_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
                (hit && !clr) |=> (st_q.val == $past(addr))); // R8
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val = st_q.val;
endmodule

// File: rtl/ecc_errlog_regs.sv
module ecc_errlog_regs
    import ecc_errlog_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter int          ERR_ADDR_W = 32,
    parameter logic [31:0] UNLOCK_KEY = DEFAULT_KEY
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic                  ce_pulse,
    input  logic                  ue_pulse,
    input  logic [ERR_ADDR_W-1:0] err_addr,
    output logic                  irq,
    output logic                  cfg_ecc_on,
    output logic                  cfg_ddr4
);
    localparam logic [ADDR_W-1:0] A_KEY   = ADDR_W'(OFS_KEY);
    localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_ICTL  = ADDR_W'(OFS_ICTL);
    localparam logic [ADDR_W-1:0] A_UEADR = ADDR_W'(OFS_UEADR);
    localparam logic [ADDR_W-1:0] A_CEADR = ADDR_W'(OFS_CEADR);

    ctl_state_t st_d, st_q;

    logic                  wr_cfg, wr_ictl, clear_now;
    logic [CE_CNT_W-1:0]   ce_cnt;
    logic [UE_CNT_W-1:0]   ue_cnt;
    logic [ERR_ADDR_W-1:0] ue_addr_val, ce_addr_val;

    // gated write decode: only the key register is writable while locked
    assign wr_cfg    = bus_we && st_q.unlocked && (bus_addr == A_CFG);
    assign wr_ictl   = bus_we && st_q.unlocked && (bus_addr == A_ICTL);
    assign clear_now = st_q.clr || (wr_ictl && bus_wdata[CLR_BIT]);

    always_comb begin
        st_d = st_q;
        if (bus_we && bus_addr == A_KEY)
            st_d.unlocked = (bus_wdata == UNLOCK_KEY);
        if (wr_cfg)
            st_d.cfg = bus_wdata;
        if (wr_ictl) begin
            st_d.en  = bus_wdata[1:0];
            st_d.clr = bus_wdata[CLR_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    errlog_satcnt #(.W(CE_CNT_W)) u_ce_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clear_now), .inc(ce_pulse), .cnt(ce_cnt)
    );

    errlog_satcnt #(.W(UE_CNT_W)) u_ue_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clear_now), .inc(ue_pulse), .cnt(ue_cnt)
    );

    errlog_addr_hold #(.W(ERR_ADDR_W), .KEEP_FIRST(1'b1)) u_ue_addr (
        .clk(clk), .rst_n(rst_n), .clr(clear_now), .hit(ue_pulse),
        .addr(err_addr), .val(ue_addr_val)
    );

    errlog_addr_hold #(.W(ERR_ADDR_W), .KEEP_FIRST(1'b0)) u_ce_addr (
        .clk(clk), .rst_n(rst_n), .clr(clear_now), .hit(ce_pulse),
        .addr(err_addr), .val(ce_addr_val)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_KEY:   bus_rdata[0] = st_q.unlocked;
            A_CFG:   bus_rdata    = st_q.cfg;
            A_ICTL: begin
                bus_rdata[CLR_BIT]                   = st_q.clr;
                bus_rdata[CE_CNT_LSB +: CE_CNT_W]    = ce_cnt;
                bus_rdata[UE_CNT_LSB +: UE_CNT_W]    = ue_cnt;
                bus_rdata[1:0]                       = st_q.en;
            end
            A_UEADR: bus_rdata = 32'(ue_addr_val);
            A_CEADR: bus_rdata = 32'(ce_addr_val);
            default: bus_rdata = '0;
        endcase
    end

    assign irq        = (st_q.en[0] && ce_cnt != '0) || (st_q.en[1] && ue_cnt != '0);
    assign cfg_ecc_on = st_q.cfg[CFG_ECC_BIT];
    assign cfg_ddr4   = st_q.cfg[CFG_TYPE_BIT];

    AST_LOCKED_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.unlocked |=> $stable(st_q.cfg)); // R3
    AST_LOCKED_ICTL: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.unlocked |=> ($stable(st_q.en) && $stable(st_q.clr))); // R3
    AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        clear_now |=> !irq); // R5
    AST_KEY_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_KEY && bus_wdata == UNLOCK_KEY) |=> st_q.unlocked); // R2
endmodule

// File: tb/ecc_errlog_regs_tb_top.sv
module ecc_errlog_regs_tb_top;
    localparam logic [31:0] KEY = 32'hFC60_0309;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ce_pulse = 1'b0, ue_pulse = 1'b0;
    logic [31:0] err_addr = '0;
    logic        irq, cfg_ecc_on, cfg_ddr4;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    ecc_errlog_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ce_pulse(ce_pulse),
        .ue_pulse(ue_pulse), .err_addr(err_addr), .irq(irq),
        .cfg_ecc_on(cfg_ecc_on), .cfg_ddr4(cfg_ddr4)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic ce, input logic ue, input logic [31:0] a);
        ce_pulse = ce; ue_pulse = ue; err_addr = a;
        @(negedge clk);
        ce_pulse = 1'b0; ue_pulse = 1'b0;
    endtask

    function automatic logic [31:0] ictl_exp(input int ce, input int ue, input logic [1:0] en);
        return (32'(ce) << 16) | (32'(ue) << 12) | 32'(en);
    endfunction

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, v); check("R1 key", v, 0);
        rd(8'h04, v); check("R1 cfg", v, 0);
        rd(8'h50, v); check("R1 ictl", v, 0);
        rd(8'h58, v); check("R1 ueaddr", v, 0);
        rd(8'h5C, v); check("R1 ceaddr", v, 0);
        check("R1 outs", {29'b0, irq, cfg_ecc_on, cfg_ddr4}, 0);

        // R3 locked writes ignored
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); check("R3 cfg locked", v, 0);
        check("R3 cfg outs", {cfg_ecc_on, cfg_ddr4}, 0);
        wr(8'h50, 32'h8000_0003); rd(8'h50, v); check("R3 ictl locked", v, 0);

        // R2 unlock
        wr(8'h00, KEY); rd(8'h00, v); check("R2 unlocked", v, 1);

        // R4 configuration bit sweep
        for (int i = 0; i < 4; i++) begin
            logic [31:0] d;
            d = 32'h1234_0000 | (i[1] ? 32'h80 : 0) | (i[0] ? 32'h10 : 0);
            wr(8'h04, d);
            rd(8'h04, v); check("R4 cfg readback", v, d);
            check("R4 cfg pins", {30'b0, cfg_ecc_on, cfg_ddr4}, 32'(i));
        end

        // R2 relock with complement, R3 write refused
        wr(8'h00, ~KEY); rd(8'h00, v); check("R2 relocked", v, 0);
        wr(8'h04, 32'h0); rd(8'h04, v); check("R3 cfg held", v, 32'h1234_0090);
        wr(8'h00, KEY);

        // R6 R8 R9 correctable sweep past saturation
        wr(8'h50, 32'h3);
        check("R9 idle irq", 32'(irq), 0);
        for (int i = 1; i <= 260; i++) begin
            pulse(1'b1, 1'b0, 32'(i * 4));
            rd(8'h50, v); check("R6 ce count", v, ictl_exp(i > 255 ? 255 : i, 0, 2'b11));
            rd(8'h5C, v); check("R8 ce last addr", v, 32'(i * 4));
            check("R9 irq ce", 32'(irq), 1);
        end

        // R5 clear holds and discards pulses
        wr(8'h50, 32'h8000_0003);
        rd(8'h50, v); check("R5 cleared", v, 32'h8000_0003);
        check("R5 irq low", 32'(irq), 0);
        pulse(1'b1, 1'b1, 32'hDEAD_0000);
        rd(8'h50, v); check("R5 pulses dropped", v, 32'h8000_0003);
        rd(8'h5C, v); check("R5 ceaddr zero", v, 0);
        rd(8'h58, v); check("R5 ueaddr zero", v, 0);
        wr(8'h50, 32'h3);

        // R6 R7 uncorrectable sweep
        for (int i = 1; i <= 20; i++) begin
            pulse(1'b0, 1'b1, 32'h1000 + 32'(i));
            rd(8'h50, v); check("R6 ue count", v, ictl_exp(0, i > 15 ? 15 : i, 2'b11));
            rd(8'h58, v); check("R7 ue first addr", v, 32'h1001);
        end

        // R9 enable sweep with both counts nonzero, then only ue nonzero
        pulse(1'b1, 1'b0, 32'h40);
        for (int e = 0; e < 4; e++) begin
            wr(8'h50, 32'(e));
            check("R9 irq both", 32'(irq), 32'(e != 0));
        end
        wr(8'h50, 32'h8000_0000); wr(8'h50, 32'h0);
        pulse(1'b0, 1'b1, 32'h50);
        for (int e = 0; e < 4; e++) begin
            wr(8'h50, 32'(e));
            check("R9 irq ue only", 32'(irq), 32'(e >= 2));
        end

        // R10 read-only and unmapped
        wr(8'h58, 32'hFFFF_FFFF); rd(8'h58, v); check("R10 ueaddr ro", v, 32'h50);
        wr(8'h5C, 32'hFFFF_FFFF); rd(8'h5C, v); check("R10 ceaddr ro", v, 0);
        rd(8'h10, v); check("R10 unmapped", v, 0);

        // R5 clear wins in same cycle, then R7 re-arm
        wr(8'h50, 32'h3);
        bus_addr = 8'h50; bus_wdata = 32'h8000_0003; bus_we = 1'b1;
        ue_pulse = 1'b1; ce_pulse = 1'b1; err_addr = 32'hBEEF;
        @(negedge clk);
        bus_we = 1'b0; ue_pulse = 1'b0; ce_pulse = 1'b0;
        rd(8'h50, v); check("R5 clear wins", v, 32'h8000_0003);
        rd(8'h58, v); check("R5 clear wins addr", v, 0);
        wr(8'h50, 32'h3);
        pulse(1'b0, 1'b1, 32'hCAFE);
        pulse(1'b0, 1'b1, 32'hF00D);
        rd(8'h58, v); check("R7 rearmed", v, 32'hCAFE);
        rd(8'h50, v); check("R6 ue after rearm", v, ictl_exp(0, 2, 2'b11));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule